// File: doc/BRIEF.md
# Segment LCD Phase Waveform Sequencer

This block produces the logic-level drive pattern for a multiplexed segment LCD. A frame tick moves a phase counter through one to eight phases, and a 3-bit duty setting chooses how many phases are used. Every pin has an 8-bit waveform word, and bit k of that word applies to phase k. A pin marked in the backplane mask goes high in each phase whose bit is set. Any other enabled pin is a frontplane, and it outputs the segment bit of its word for the current phase.

Configuration inputs set the display view. Normal view uses the low bits of each word. Alternate view uses the upper half of each word, and it is allowed only when four or fewer phases are in use. Blank view turns all frontplanes off while the backplanes keep running. A blink timer counts LCD clock ticks and, once per period, switches the display into an off interval. During that interval the display shows either the blank view or the alternate view.

A sticky frame flag records each wrap of the phase counter, and an interrupt output follows that flag when the interrupt is enabled. Analog bias levels, the charge pump and clock source selection are handled outside this block.

Top module: `lcd_phase_seq`

## Requirements
- R1: With duty value d (0..7), the phase counter steps by one on each frame_tick while enabled. It returns to 0 on the tick taken at phase d, and also on a tick taken at any phase above d.
- R2: A write with wr_en stores wr_data into the waveform word of pin wr_addr. Bit k of the word is used in phase k, with bit 0 for the first phase.
- R3: A pin whose bp_mask bit is 1 is a backplane. It outputs the bit of its word for the current phase, and it does so in every view, blank included.
- R4: In normal view (disp_mode 0) an enabled frontplane pin outputs the bit of its word for the current phase.
- R5: While en is 0, every pin_out bit is 0 and phase is held at 0.
- R6: A pin whose pin_en bit is 0 always outputs 0.
- R7: disp_mode 1 selects the alternate view when duty is 3 or less. In that view, phase p uses bit p+4 of each word, for both pin kinds. When duty is 4 or more, disp_mode 1 behaves as normal view.
- R8: disp_mode 2 or 3 selects the blank view. In blank view every frontplane outputs 0 and the backplanes keep sequencing.
- R9: While en and blink_en are both 1, a counter advances on each lcd_tick. The counter is cleared while either of them is 0. With rate r, the counter value c lies in the blink-off interval when bit (BLINK_BASE-1+r) of c is set. This gives a blink period of 2^(BLINK_BASE+r) ticks, and the second half of each period is off.
- R10: In the blink-off interval the view is alternate when blink_alt is 1 and duty is 3 or less. Otherwise the view is blank. This choice overrides disp_mode.
- R11: frame_flag becomes 1 on the cycle after a phase wrap. flag_clr clears it, and a wrap in the same cycle wins over the clear. irq equals frame_flag AND irq_en.
- R12: pin_out is registered. A change of phase, configuration or waveform word appears on pin_out one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable |
| duty | input | 3 | Active phase count minus one |
| disp_mode | input | 2 | 0 normal, 1 alternate, 2/3 blank |
| blink_en | input | 1 | Blink enable |
| blink_alt | input | 1 | Off interval shows alternate view (else blank) |
| blink_rate | input | 3 | Blink period exponent offset |
| pin_en | input | NPINS | Per-pin enable |
| bp_mask | input | NPINS | Per-pin backplane designation |
| irq_en | input | 1 | Frame interrupt enable |
| frame_tick | input | 1 | Advance to next phase |
| lcd_tick | input | 1 | LCD clock enable for blink timer |
| wr_en | input | 1 | Waveform word write strobe |
| wr_addr | input | $clog2(NPINS) | Pin index to write |
| wr_data | input | 8 | Waveform word |
| flag_clr | input | 1 | Clear frame flag (write one) |
| pin_out | output | NPINS | Pin drive levels |
| phase | output | 3 | Current phase |
| frame_flag | output | 1 | Sticky frame wrap flag |
| irq | output | 1 | Frame interrupt |

## Verification
The assertions check on every cycle that the phase counter steps or wraps correctly for the current duty value. They also check that disabled pins and a cleared global enable give low outputs, that frontplanes stay off one cycle after a blank view, that the blink counter is cleared when blinking stops, and that the frame flag sets on a wrap and clears on a clear request. Only the bench scenarios show that the right waveform bit reaches each pin. These scenarios cover several duty values, the fallback from alternate to normal when more than four phases are in use, the timing of the blink-off interval and its choice between blank and alternate, and the rewrite of a waveform word.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    VIEW_MAIN  = 2'd0,
    VIEW_ALT   = 2'd1,
    VIEW_BLANK = 2'd2
  } view_e;
endpackage

// File: rtl/lcd_phase_ctr.sv
module lcd_phase_ctr #(
  parameter int NPH = 8,
  localparam int PW = $clog2(NPH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic [PW-1:0] duty,
  output logic [PW-1:0] phase,
  output logic          wrap
);
  assign wrap = en && tick && (phase >= duty);

  always_ff @(posedge clk) begin
    if (rst || !en)
      phase <= '0;
    else if (tick)
      phase <= wrap ? '0 : phase + 1'b1;
  end

  // R1: the last active phase (or beyond) returns to zero
  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (en && tick && phase >= duty) |=> (phase == '0));
  // R1: single step below the last active phase
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (en && tick && phase < duty) |=> (phase == $past(phase) + 1'b1));
  // R5: phase held at zero while disabled
  a_r5_phase_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase == '0));
endmodule

// File: rtl/lcd_blink_gen.sv
module lcd_blink_gen #(
  parameter int BASE = 12,
  parameter int RW   = 3,
  localparam int CW  = BASE + (1 << RW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          lcd_tick,
  input  logic [RW-1:0] rate,
  output logic          blink_off
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (lcd_tick)
      cnt <= cnt + 1'b1;
  end

  assign blink_off = run && cnt[BASE - 1 + int'(rate)];

  // R9: counter restarts whenever blinking is not running
  a_r9_cleared: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
  // R9: counter holds without an LCD tick
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !lcd_tick) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/lcd_pin_drive.sv
module lcd_pin_drive
  import lcd_seq_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int NPH   = 8,
  localparam int PW   = $clog2(NPH),
  localparam int HALF = NPH / 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [NPINS-1:0] pin_en,
  input  logic [NPINS-1:0] bp_mask,
  input  view_e            view,
  input  logic [PW-1:0]    phase,
  input  logic [NPH-1:0]   wf [NPINS],
  output logic [NPINS-1:0] pin_out
);
  logic [PW-1:0]    idx;
  logic [NPINS-1:0] nxt;

  assign idx = (view == VIEW_ALT) ? phase + PW'(HALF) : phase;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign nxt[i] = en && pin_en[i] && wf[i][idx] &&
                    (bp_mask[i] || view != VIEW_BLANK);
  end

  always_ff @(posedge clk) begin
    if (rst) pin_out <= '0;
    else     pin_out <= nxt;
  end

  // R5: global disable forces every pin low
  a_r5_all_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pin_out == '0));
  // R6: disabled pins never drive high
  a_r6_pin_low: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pin_out & ~$past(pin_en)) == '0));
  // R8: blank view leaves only backplanes able to drive
  a_r8_blank_fp: assert property (@(posedge clk) disable iff (rst)
    (view == VIEW_BLANK) |=> ((pin_out & ~$past(bp_mask)) == '0));
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_seq_pkg::*;
#(
  parameter int NPINS      = 16,
  parameter int NPH        = 8,
  parameter int BLINK_BASE = 12,
  parameter int RATE_W     = 3,
  localparam int PW        = $clog2(NPH),
  localparam int AW        = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int HALF      = NPH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PW-1:0]     duty,
  input  logic [1:0]        disp_mode,
  input  logic              blink_en,
  input  logic              blink_alt,
  input  logic [RATE_W-1:0] blink_rate,
  input  logic [NPINS-1:0]  pin_en,
  input  logic [NPINS-1:0]  bp_mask,
  input  logic              irq_en,
  input  logic              frame_tick,
  input  logic              lcd_tick,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [NPH-1:0]    wr_data,
  input  logic              flag_clr,
  output logic [NPINS-1:0]  pin_out,
  output logic [PW-1:0]     phase,
  output logic              frame_flag,
  output logic              irq
);
  logic [NPH-1:0] wf_q [NPINS];
  logic           wrap;
  logic           blink_off;
  logic           alt_ok;
  view_e          view;

  always_ff @(posedge clk) begin
    if (wr_en && int'(wr_addr) < NPINS)
      wf_q[wr_addr] <= wr_data;
  end

  lcd_phase_ctr #(.NPH(NPH)) u_phase (
    .clk(clk), .rst(rst), .en(en), .tick(frame_tick),
    .duty(duty), .phase(phase), .wrap(wrap)
  );

  lcd_blink_gen #(.BASE(BLINK_BASE), .RW(RATE_W)) u_blink (
    .clk(clk), .rst(rst), .run(en && blink_en), .lcd_tick(lcd_tick),
    .rate(blink_rate), .blink_off(blink_off)
  );

  assign alt_ok = (int'(duty) < HALF);

  always_comb begin
    if (blink_off)
      view = (blink_alt && alt_ok) ? VIEW_ALT : VIEW_BLANK;
    else begin
      unique case (disp_mode)
        2'd0:    view = VIEW_MAIN;
        2'd1:    view = alt_ok ? VIEW_ALT : VIEW_MAIN;
        default: view = VIEW_BLANK;
      endcase
    end
  end

  lcd_pin_drive #(.NPINS(NPINS), .NPH(NPH)) u_drive (
    .clk(clk), .rst(rst), .en(en), .pin_en(pin_en), .bp_mask(bp_mask),
    .view(view), .phase(phase), .wf(wf_q), .pin_out(pin_out)
  );

  always_ff @(posedge clk) begin
    if (rst)           frame_flag <= 1'b0;
    else if (wrap)     frame_flag <= 1'b1;
    else if (flag_clr) frame_flag <= 1'b0;
  end

  assign irq = frame_flag & irq_en;

  // R11: a wrap always leaves the flag set
  a_r11_set: assert property (@(posedge clk) disable iff (rst)
    wrap |=> frame_flag);
  // R11: a clear without a wrap drops the flag
  a_r11_clr: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !wrap) |=> !frame_flag);
  // R7: alternate view never chosen with more than half the phases
  a_r7_alt_limit: assert property (@(posedge clk) disable iff (rst)
    (view == VIEW_ALT) |-> (int'(duty) < HALF));
endmodule

// File: tb/sim_lcd_phase_seq.sv
module sim_lcd_phase_seq;
  localparam int NP = 16;
  localparam int BB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 0, blink_en = 0, blink_alt = 0, irq_en = 0;
  logic frame_tick = 0, lcd_tick = 0, wr_en = 0, flag_clr = 0;
  logic [2:0] duty = 0, blink_rate = 0;
  logic [1:0] disp_mode = 0;
  logic [NP-1:0] pin_en = '0, bp_mask = '0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [NP-1:0] pin_out;
  logic [2:0] phase;
  logic frame_flag, irq;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] wfm [NP];

  // {duty[2:0], disp_mode[1:0]}
  localparam logic [4:0] VEC [8] = '{
    {3'd7, 2'd0}, {3'd3, 2'd0}, {3'd0, 2'd0}, {3'd3, 2'd1},
    {3'd5, 2'd1}, {3'd2, 2'd2}, {3'd4, 2'd0}, {3'd1, 2'd3}
  };

  always #5 clk = ~clk;

  lcd_phase_seq #(.NPINS(NP), .BLINK_BASE(BB)) u0 (
    .clk(clk), .rst(rst), .en(en), .duty(duty), .disp_mode(disp_mode),
    .blink_en(blink_en), .blink_alt(blink_alt), .blink_rate(blink_rate),
    .pin_en(pin_en), .bp_mask(bp_mask), .irq_en(irq_en),
    .frame_tick(frame_tick), .lcd_tick(lcd_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .flag_clr(flag_clr),
    .pin_out(pin_out), .phase(phase), .frame_flag(frame_flag), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic step_phase();
    frame_tick = 1; @(negedge clk);
    frame_tick = 0; @(negedge clk);
  endtask

  // view: 0 main, 1 alternate, 2 blank
  function automatic logic [NP-1:0] model(int ph, int d, int md, bit boff, bit balt);
    logic [NP-1:0] r;
    int v;
    bit altok = (d < 4);
    if (boff)         v = (balt && altok) ? 1 : 2;
    else if (md == 1) v = altok ? 1 : 0;
    else if (md >= 2) v = 2;
    else              v = 0;
    for (int i = 0; i < NP; i++) begin
      int idx = (v == 1) ? ph + 4 : ph;
      logic b = wfm[i][idx];
      if (!pin_en[i]) b = 0;
      if (!bp_mask[i] && v == 2) b = 0;
      r[i] = b;
    end
    return r;
  endfunction

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int ph;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R5 reset pin_out", pin_out, 0);
    chk("R1 reset phase", phase, 0);
    chk("R11 reset flag", frame_flag, 0);

    // R2: load waveform words
    pin_en = 16'h7FFF;  // pin 15 disabled
    bp_mask = 16'h000F; // pins 0..3 backplanes
    irq_en = 1;
    for (int i = 0; i < NP; i++) begin
      if (i < 4) wfm[i] = 8'((1 << i) | (1 << (i + 4)));
      else if (i == 15) wfm[i] = 8'hFF;
      else wfm[i] = 8'(i * 29 + 7);
      wr_en = 1; wr_addr = 4'(i); wr_data = wfm[i];
      @(negedge clk);
    end
    wr_en = 0;

    // table walk: R1 R3 R4 R5 R6 R7 R8 R12
    for (int v = 0; v < 8; v++) begin
      en = 0;
      duty = VEC[v][4:2];
      disp_mode = VEC[v][1:0];
      settle();
      chk("R5 disabled pins low", pin_out, 0);
      chk("R5 disabled phase zero", phase, 0);
      en = 1;
      settle();
      ph = 0;
      for (int k = 0; k <= 2 * (int'(duty) + 1); k++) begin
        chk("R1 phase sequence", phase, ph);
        chk("R3/R4/R6/R7/R8 pins", pin_out, model(ph, duty, disp_mode, 0, 0));
        step_phase();
        ph = (ph == int'(duty)) ? 0 : ph + 1;
      end
    end

    // R12: one-cycle latency after a single phase step
    duty = 3'd7; disp_mode = 0;
    en = 0; @(negedge clk); en = 1; @(negedge clk);
    frame_tick = 1; @(negedge clk); frame_tick = 0;
    chk("R12 phase stepped", phase, 1);
    chk("R12 pins not yet", pin_out, model(0, 7, 0, 0, 0));
    @(negedge clk);
    chk("R12 pins follow", pin_out, model(1, 7, 0, 0, 0));

    // R1: phase above a lowered duty wraps to zero
    repeat (4) step_phase();
    chk("R1 reached phase 5", phase, 5);
    duty = 3'd2;
    step_phase();
    chk("R1 wrap above duty", phase, 0);

    // R2: rewrite a word while running
    wfm[5] = 8'hA5;
    wr_en = 1; wr_addr = 4'd5; wr_data = 8'hA5; @(negedge clk); wr_en = 0;
    @(negedge clk);
    chk("R2 rewritten word", pin_out, model(0, 2, 0, 0, 0));

    // R11: flag clear, irq gating, set wins over clear
    flag_clr = 1; @(negedge clk); flag_clr = 0; @(negedge clk);
    chk("R11 flag cleared", frame_flag, 0);
    chk("R11 irq low", irq, 0);
    duty = 3'd0;
    frame_tick = 1; flag_clr = 1; @(negedge clk);
    frame_tick = 0; flag_clr = 0; @(negedge clk);
    chk("R11 set wins over clear", frame_flag, 1);
    chk("R11 irq follows flag", irq, 1);
    irq_en = 0; #1;
    chk("R11 irq masked", irq, 0);

    // R9 R10: blink with alternate view, rate 1, period 32
    duty = 3'd3; disp_mode = 0; lcd_tick = 1;
    blink_alt = 1; blink_rate = 3'd1;
    en = 0; @(negedge clk); en = 1; @(negedge clk);
    blink_en = 1;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      chk("R9/R10 blink alternate", pin_out, model(0, 3, 0, ((k >> (BB)) & 1) != 0, 1));
    end

    // R10: alternate not allowed with six phases -> blank, rate 0
    blink_en = 0; @(negedge clk);
    duty = 3'd5; blink_rate = 3'd0;
    blink_en = 1;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      chk("R9/R10 blink blank", pin_out, model(0, 5, 0, ((k >> (BB - 1)) & 1) != 0, 1));
    end
    blink_en = 0;
    @(negedge clk);
    en = 0; settle();
    chk("R5 final disable", pin_out, 0);
    summary();
  end
endmodule